// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Reader

This block sits on the host side of a slow delta-sigma converter that has a three-wire read port: an active-low chip-select, a serial clock driven by the host, and a serial data line driven by the converter. On a read request it lowers chip-select, waits out a setup interval, and then produces one serial clock pulse per bit of the conversion word. It samples the data line on each rising edge, most significant bit first. When the last bit is in, it splits the word into a flags field and a data field, pulses a done strobe for one cycle, and only then raises chip-select.

The serial clock line also sets the converter's power state. A high level held long enough sends the converter to sleep, so the reader keeps the line low whenever it is idle and times every high phase of a burst. On a sleep request it drives the line high, with chip-select high, for a programmed number of cycles and then reports sleep. A read issued while asleep first holds the line low for a programmed wake interval before chip-select falls.

The rate of the serial clock is set by a half-period divider. At the default divider and a 125 MHz system clock the serial clock runs below 2 MHz with a 50 % duty cycle.

Top module: `dsadc_reader`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, done is 0, asleep is 0, and flags_q and data_q are all zero.
- R2: In a read burst, the first rising edge of sclk comes exactly CS_SETUP + HALF_DIV system cycles after cs_n falls.
- R3: While cs_n is low, every high phase of sclk lasts exactly HALF_DIV cycles, and every low phase between two pulses lasts exactly HALF_DIV cycles.
- R4: A burst has exactly FLAG_W + DATA_W rising edges of sclk, and sdo is sampled at each one. The first bit sampled is the MSB of flags_q. The next FLAG_W - 1 bits fill the rest of flags_q, and the last DATA_W bits fill data_q, MSB first.
- R5: done is high for exactly one cycle. It comes right after the high phase of the last pulse, with cs_n still low. cs_n rises in the next cycle, so cs_n is low for CS_SETUP + 2*HALF_DIV*(FLAG_W+DATA_W) + 1 cycles.
- R6: sdo is ignored while cs_n is high: toggling it between bursts leaves flags_q and data_q at the last word read.
- R7: A read request or a sleep request made during a burst is dropped. No second burst follows, the reader does not enter sleep, and sclk stays low afterwards.
- R8: A sleep request from idle holds sclk high and cs_n high for SLEEP_CYC cycles. After that asleep becomes 1 and sclk stays high.
- R9: A read request while asleep clears asleep and holds sclk low, with cs_n high, for exactly WAKE_CYC cycles. cs_n then falls and a normal burst follows.
- R10: When a read request and a sleep request arrive in the same idle cycle, the read is performed and the sleep request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read one conversion word (single-cycle pulse) |
| slp_req | input | 1 | Put the converter to sleep (single-cycle pulse) |
| sdo | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip-select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| flags_q | output | FLAG_W | Flags field of the last word read |
| data_q | output | DATA_W | Data field of the last word read |
| done | output | 1 | One-cycle strobe when a new word is valid |
| asleep | output | 1 | Converter has been put to sleep |

## Verification
The bench targets these corner cases:
- Every bit position, using walking ones and dense patterns. An off-by-one bit counter would show up as a shifted or truncated word, or a wrong pulse count.
- The edge timing around chip-select. A reader that lets the first edge come before the setup interval, or raises chip-select before done, changes the measured setup time or the low-time of chip-select.
- The sleep and wake hold lengths. A wrong hold could let the converter fall asleep in the middle of a read, or let a read start before the converter is awake.
- Requests that arrive during a burst, and a read and a sleep request in the same cycle. A reader that gives the wrong request priority would start a second burst or fall asleep.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_DONE,
    ST_SLPGO,
    ST_SLEPT,
    ST_WAKE
  } rdr_state_e;

  // Bits needed to hold the value v.
  function automatic int bits_for(input int v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Cycles chip-select stays low for one burst: setup, two phases per bit, one done cycle.
  function automatic int burst_cycles(input int setup, input int half, input int nbits);
    return setup + 2 * half * nbits + 1;
  endfunction

endpackage

// File: rtl/dsadc_phase_timer.sv
module dsadc_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len_m1,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len_m1;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/dsadc_shift_in.sv
module dsadc_shift_in #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word <= '0;
    else if (shift) word <= {word[W-2:0], din};
  end

endmodule

// File: rtl/dsadc_reader.sv
module dsadc_reader
  import dsadc_pkg::*;
#(
  parameter int FLAG_W    = 4,
  parameter int DATA_W    = 20,
  parameter int HALF_DIV  = 32,
  parameter int CS_SETUP  = 26,
  parameter int WAKE_CYC  = 1250,
  parameter int SLEEP_CYC = 262500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              slp_req,
  input  logic              sdo,
  output logic              cs_n,
  output logic              sclk,
  output logic [FLAG_W-1:0] flags_q,
  output logic [DATA_W-1:0] data_q,
  output logic              done,
  output logic              asleep
);

  localparam int NBITS = FLAG_W + DATA_W;
  localparam int CW    = bits_for(max4(HALF_DIV, CS_SETUP, WAKE_CYC, SLEEP_CYC));
  localparam int BW    = bits_for(NBITS - 1);
  localparam int CHK_W = CW + 1;
  localparam logic [CW-1:0] LEN_SETUP = CW'(CS_SETUP - 1);
  localparam logic [CW-1:0] LEN_HALF  = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] LEN_WAKE  = CW'(WAKE_CYC - 1);
  localparam logic [CW-1:0] LEN_SLEEP = CW'(SLEEP_CYC - 1);

  rdr_state_e       state, nxt;
  logic [CW-1:0]    len_m1;
  logic             phase_end, load;
  logic [BW-1:0]    bits_left;
  logic             last_bit, rise_ev, cap_ev;
  logic [NBITS-1:0] shreg;

  assign last_bit = (bits_left == '0);
  assign rise_ev  = (state == ST_LOW) && phase_end;
  assign cap_ev   = (state == ST_HIGH) && phase_end && last_bit;

  always_comb begin
    nxt    = state;
    len_m1 = '0;
    unique case (state)
      ST_IDLE: begin
        if (rd_req)       begin nxt = ST_SETUP; len_m1 = LEN_SETUP; end
        else if (slp_req) begin nxt = ST_SLPGO; len_m1 = LEN_SLEEP; end
      end
      ST_SETUP: if (phase_end) begin nxt = ST_LOW;  len_m1 = LEN_HALF; end
      ST_LOW:   if (phase_end) begin nxt = ST_HIGH; len_m1 = LEN_HALF; end
      ST_HIGH: begin
        if (phase_end) begin
          if (last_bit) nxt = ST_DONE;
          else begin nxt = ST_LOW; len_m1 = LEN_HALF; end
        end
      end
      ST_DONE:  nxt = ST_IDLE;
      ST_SLPGO: if (phase_end) nxt = ST_SLEPT;
      ST_SLEPT: if (rd_req) begin nxt = ST_WAKE; len_m1 = LEN_WAKE; end
      ST_WAKE:  if (phase_end) begin nxt = ST_SETUP; len_m1 = LEN_SETUP; end
      default:  nxt = ST_IDLE;
    endcase
  end

  assign load = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  dsadc_phase_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .len_m1  (len_m1),
    .expired (phase_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bits_left <= '0;
    else if (state == ST_SETUP && phase_end)
      bits_left <= BW'(NBITS - 1);
    else if (state == ST_HIGH && phase_end && !last_bit)
      bits_left <= bits_left - 1'b1;
  end

  dsadc_shift_in #(.W(NBITS)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (rise_ev),
    .din   (sdo),
    .word  (shreg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      data_q  <= '0;
    end else if (cap_ev) begin
      flags_q <= shreg[NBITS-1:DATA_W];
      data_q  <= shreg[DATA_W-1:0];
    end
  end

  assign sclk   = (state == ST_HIGH) || (state == ST_SLPGO) || (state == ST_SLEPT);
  assign cs_n   = !((state == ST_SETUP) || (state == ST_LOW) ||
                    (state == ST_HIGH)  || (state == ST_DONE));
  assign done   = (state == ST_DONE);
  assign asleep = (state == ST_SLEPT);

  // ---------------- assertion support: run-length observers on the pins ----------------
  logic             sclk_q;
  logic [CHK_W-1:0] hi_run, lo_run, cs_low_run, hi_idle_run, lo_idle_run;
  logic [BW:0]      rise_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= 1'b0;
      hi_run      <= '0;
      lo_run      <= '0;
      cs_low_run  <= '0;
      hi_idle_run <= '0;
      lo_idle_run <= '0;
      rise_cnt    <= '0;
    end else begin
      sclk_q      <= sclk;
      hi_run      <= !sclk ? '0 : ((hi_run == '1) ? hi_run : hi_run + 1'b1);
      lo_run      <= sclk ? '0 : ((lo_run == '1) ? lo_run : lo_run + 1'b1);
      cs_low_run  <= cs_n ? '0 : ((cs_low_run == '1) ? cs_low_run : cs_low_run + 1'b1);
      hi_idle_run <= !(sclk && cs_n) ? '0 :
                     ((hi_idle_run == '1) ? hi_idle_run : hi_idle_run + 1'b1);
      lo_idle_run <= !(!sclk && cs_n) ? '0 :
                     ((lo_idle_run == '1) ? lo_idle_run : lo_idle_run + 1'b1);
      rise_cnt    <= cs_n ? '0 : ((sclk && !sclk_q) ? rise_cnt + 1'b1 : rise_cnt);
    end
  end

  AST_FIRST_EDGE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !cs_n && rise_cnt == '0) |-> cs_low_run == CHK_W'(CS_SETUP + HALF_DIV))
    else $error("first edge setup");  // R2
  AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && !cs_n) |-> hi_run == CHK_W'(HALF_DIV))
    else $error("high phase width");  // R3
  AST_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !cs_n && rise_cnt != '0) |-> lo_run == CHK_W'(HALF_DIV))
    else $error("low phase width");  // R3
  AST_BIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rise_cnt == (BW+1)'(NBITS))
    else $error("bit count");  // R4
  AST_DONE_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cs_n && !done))
    else $error("release after done");  // R5
  AST_RELEASE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(done))
    else $error("release without done");  // R5
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> hi_idle_run >= CHK_W'(SLEEP_CYC))
    else $error("sleep hold");  // R8
  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && $past(state == ST_WAKE)) |-> lo_idle_run >= CHK_W'(WAKE_CYC))
    else $error("wake hold");  // R9

endmodule

// File: tb/tb_dsadc_reader.sv
module tb_dsadc_reader;

  localparam int FW = 4, DW = 20, HALF = 3, SETUP = 2, WAKE = 12, SLEEP = 40;
  localparam int NB = FW + DW;
  localparam int BURST = SETUP + 2 * HALF * NB + 1;

  logic clk = 1'b0, rst_n = 1'b0, rd_req = 1'b0, slp_req = 1'b0, sdo = 1'b0;
  logic cs_n, sclk, done, asleep;
  logic [FW-1:0] flags_q;
  logic [DW-1:0] data_q;

  always #4 clk = ~clk;

  dsadc_reader #(.FLAG_W(FW), .DATA_W(DW), .HALF_DIV(HALF), .CS_SETUP(SETUP),
                 .WAKE_CYC(WAKE), .SLEEP_CYC(SLEEP)) dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .slp_req(slp_req), .sdo(sdo),
    .cs_n(cs_n), .sclk(sclk), .flags_q(flags_q), .data_q(data_q),
    .done(done), .asleep(asleep));

  int nchk = 0, nfail = 0;
  logic [NB-1:0] cur = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Converter model and pin observer, sampling at the falling edge of clk.
  logic cs_p = 1'b1, sclk_p = 1'b0, done_p = 1'b0, asleep_p = 1'b0;
  int idx = 0, hrun = 0, lrun = 0, cslow = 0, hi_idle = 0, lo_idle = 0;
  int rises = 0, setup_meas = 0, hi_bad = 0, lo_bad = 0, done_cnt = 0;
  int burst_len = 0, last_done = 0, bursts = 0, wake_low = 0, slp_hold = 0;
  bit got_first = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cs_p = 1'b1; sclk_p = 1'b0;
    end else begin
      if (cs_n) sdo = ~sdo;
      else if (cs_p) begin
        idx = NB - 1; sdo = cur[idx];
        rises = 0; got_first = 0; hi_bad = 0; lo_bad = 0; done_cnt = 0;
        wake_low = lo_idle;
      end else if (sclk_p && !sclk) begin
        if (idx > 0) idx--;
        sdo = cur[idx];
      end
      if (!cs_n && sclk && !sclk_p) begin
        if (!got_first) begin got_first = 1; setup_meas = cslow; end
        else if (lrun != HALF) lo_bad++;
        rises++;
      end
      if (!cs_n && !sclk && sclk_p && hrun != HALF) hi_bad++;
      if (done) done_cnt++;
      if (cs_n && !cs_p) begin burst_len = cslow; last_done = done_p; bursts++; end
      if (asleep && !asleep_p) slp_hold = hi_idle;
      hrun    = sclk ? hrun + 1 : 0;
      lrun    = !sclk ? lrun + 1 : 0;
      cslow   = !cs_n ? cslow + 1 : 0;
      hi_idle = (sclk && cs_n) ? hi_idle + 1 : 0;
      lo_idle = (!sclk && cs_n) ? lo_idle + 1 : 0;
      cs_p = cs_n; sclk_p = sclk; done_p = done; asleep_p = asleep;
    end
  end

  task automatic do_read(input logic [NB-1:0] w, input bit also_slp, input bit poke,
                         input bit woke);
    int b0;
    cur = w;
    b0 = bursts;
    @(negedge clk); rd_req = 1'b1; slp_req = also_slp;
    @(negedge clk); rd_req = 1'b0; slp_req = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      rd_req = 1'b1; slp_req = 1'b1;
      @(negedge clk); rd_req = 1'b0; slp_req = 1'b0;
    end
    while (bursts == b0) @(posedge clk);
    chk(data_q == w[DW-1:0], "R4", "data", data_q, w[DW-1:0]);
    chk(flags_q == w[NB-1:DW], "R4", "flags", flags_q, w[NB-1:DW]);
    chk(rises == NB, "R4", "pulses", rises, NB);
    chk(setup_meas == SETUP + HALF, "R2", "setup", setup_meas, SETUP + HALF);
    chk(hi_bad == 0 && lo_bad == 0, "R3", "phase widths", hi_bad + lo_bad, 0);
    chk(burst_len == BURST, "R5", "cs low", burst_len, BURST);
    chk(last_done == 1 && done_cnt == 1, "R5", "done", done_cnt, 1);
    if (woke) chk(wake_low == WAKE, "R9", "wake hold", wake_low, WAKE);
    if (poke || also_slp) begin
      repeat (SLEEP + 20) @(posedge clk);
      chk(bursts == b0 + 1 && cs_n, "R7", "extra burst", bursts - b0, 1);
      chk(!asleep && !sclk, also_slp ? "R10" : "R7", "sleep dropped", asleep, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !done && !asleep, "R1", "pins", {cs_n, sclk, done, asleep}, 4'b1000);
    chk(data_q == '0 && flags_q == '0, "R1", "words", data_q, 0);

    do_read('0, 0, 0, 0);
    do_read('1, 0, 0, 0);
    do_read(24'hA5A5A5, 0, 0, 0);
    do_read(24'h5A5A5A, 0, 0, 0);
    for (int i = 0; i < NB; i++) do_read(NB'(1) << i, 0, 0, 0);
    begin
      logic [NB-1:0] lf = 24'h3C91E7;
      for (int k = 0; k < 6; k++) begin
        lf = {lf[NB-2:0], lf[23] ^ lf[22] ^ lf[21] ^ lf[16]};
        do_read(lf, 0, 0, 0);
      end
    end

    // R6: sdo toggles while idle; the last word must hold.
    repeat (50) @(posedge clk);
    chk(data_q == cur[DW-1:0] && flags_q == cur[NB-1:DW], "R6", "idle hold", data_q, cur[DW-1:0]);

    // R7: requests during a burst are dropped.
    do_read(24'hC3F00F, 0, 1, 0);
    // R10: read and sleep together.
    do_read(24'h1E2D3C, 1, 0, 0);

    // R8: sleep entry.
    @(negedge clk); slp_req = 1'b1;
    @(negedge clk); slp_req = 1'b0;
    repeat (SLEEP + 10) @(posedge clk);
    chk(asleep == 1'b1, "R8", "asleep", asleep, 1);
    chk(slp_hold == SLEEP, "R8", "sleep hold", slp_hold, SLEEP);
    chk(sclk && cs_n, "R8", "lines asleep", {sclk, cs_n}, 2'b11);
    // R9: read from sleep.
    do_read(24'h8F0F71, 0, 0, 1);
    chk(!asleep, "R9", "awake", asleep, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule